// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 64-bit integer core fetches next. In a single combinational path it takes the current program counter, two register operands, a sign-extended offset, a 4-bit control code and the byte length of the current instruction. From these it produces four results:

- the next program counter;
- a flag that says the flow was redirected;
- the return address for linking jumps;
- the PC-plus-offset sum, which the core uses as a data result.

Decode, immediate extraction, the register file and hazard handling all sit outside the block.

The unit has no storage and no handshake. Every output is a pure function of the present inputs and settles within the same cycle. The parameter `HALF_OK` sets whether 2-byte instructions are legal fetch targets. When it is 0, a redirect to a target whose bit 1 is set raises a misalignment flag.

Top module: `npc_unit`

## Requirements
- R1: Control codes 0 (sequential) and the unassigned codes 4, 5, 6, 7, 14 and 15 give next_pc_o = pc_i + step with taken_o = 0.
- R2: The step is 2 when len_i equals 2 and 4 for every other len_i value.
- R3: Code 1 (direct jump) gives next_pc_o = pc_i + off_i and taken_o = 1.
- R4: Code 2 (register jump) gives next_pc_o = (opa_i + off_i) with bit 0 forced to 0, and taken_o = 1.
- R5: link_o equals pc_i + step under every control code.
- R6: Code 3 (PC-relative add) leaves the flow sequential (next_pc_o = pc_i + step, taken_o = 0). pcrel_o equals pc_i + off_i under every code.
- R7: Code 8 is taken when opa_i equals opb_i. Code 9 is taken when they differ.
- R8: Code 10 is taken when opa_i < opb_i as two's-complement numbers. Code 11 is taken when that is false.
- R9: Code 12 is taken when opa_i < opb_i as unsigned numbers. Code 13 is taken when that is false.
- R10: A taken branch gives next_pc_o = pc_i + off_i. A branch that is not taken gives next_pc_o = pc_i + step.
- R11: With HALF_OK = 0, misalign_o = taken_o AND next_pc_o[1]. With HALF_OK = 1, misalign_o is always 0.
- R12: taken_o is 1 only for codes 1 and 2 and for branch codes 8 to 13 whose condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of the current instruction |
| opa_i | input | 64 | First register operand (jump base, first compare operand) |
| opb_i | input | 64 | Second register operand (second compare operand) |
| off_i | input | 64 | Sign-extended offset |
| op_i | input | 4 | Control code, encodings as in R1 and R3 to R9 |
| len_i | input | 3 | Instruction length in bytes |
| next_pc_o | output | 64 | Address to fetch next |
| taken_o | output | 1 | Flow was redirected |
| link_o | output | 64 | Return address, pc_i + step |
| pcrel_o | output | 64 | pc_i + off_i as a data result |
| misalign_o | output | 1 | Redirect target is not 4-byte aligned (HALF_OK = 0 only) |

## Verification
The hardest cases to reach are the places where signed and unsigned ordering disagree. The operand pair -1 and 1 must be taken by the signed less-than code and not taken by the unsigned less-than code, and the bench applies that exact pair under each code. Equal operands land on the boundary of both greater-or-equal codes, so they are applied too. Misalignment is only meaningful on a redirect, so the bench takes jumps and branches to targets with bit 1 set. It then repeats the branch case with the condition false, to show that the flag stays low on fall-through.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN = 64;
  localparam int OPW  = 4;
  localparam int LENW = 3;

  typedef enum logic [OPW-1:0] {
    NPC_SEQ   = 4'd0,
    NPC_JMP   = 4'd1,
    NPC_JREG  = 4'd2,
    NPC_PCREL = 4'd3,
    NPC_BEQ   = 4'd8,
    NPC_BNE   = 4'd9,
    NPC_BLT   = 4'd10,
    NPC_BGE   = 4'd11,
    NPC_BLTU  = 4'd12,
    NPC_BGEU  = 4'd13
  } npc_op_e;

  // compare kind carried in op bits [2:1] of a branch code
  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_LT  = 2'b01,
    CMP_LTU = 2'b10,
    CMP_NONE = 2'b11
  } cmp_kind_e;
endpackage

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp
  import npc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  cmp_kind_e    kind_i,
  input  logic         invert_i,
  output logic         hit_o
);
  logic eq, lt_s, lt_u, base;

  assign eq   = (a_i == b_i);
  assign lt_s = ($signed(a_i) < $signed(b_i));
  assign lt_u = (a_i < b_i);

  always_comb begin
    unique case (kind_i)
      CMP_EQ:  base = eq;
      CMP_LT:  base = lt_s;
      CMP_LTU: base = lt_u;
      default: base = 1'b0;
    endcase
    hit_o = base ^ invert_i;
  end

  // R8/R9: equal operands are never ordered below one another
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r8_eq_not_lt: assert (!(eq && (lt_s || lt_u)));
    end
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] off_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] rel_o,
  output logic [W-1:0] reg_o
);
  logic [W-1:0] reg_sum;

  assign seq_o   = pc_i + step_i;
  assign rel_o   = pc_i + off_i;
  assign reg_sum = base_i + off_i;
  assign reg_o   = {reg_sum[W-1:1], 1'b0};

  // R4: register target stays within one byte of the raw sum
  always_comb begin
    if (!$isunknown({base_i, off_i})) begin
      a_r4_mask_bit0: assert (reg_o[0] == 1'b0 && reg_o[W-1:1] == reg_sum[W-1:1]);
    end
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XW      = XLEN,
  parameter bit HALF_OK = 1'b0
) (
  input  logic [XW-1:0]   pc_i,
  input  logic [XW-1:0]   opa_i,
  input  logic [XW-1:0]   opb_i,
  input  logic [XW-1:0]   off_i,
  input  logic [OPW-1:0]  op_i,
  input  logic [LENW-1:0] len_i,
  output logic [XW-1:0]   next_pc_o,
  output logic            taken_o,
  output logic [XW-1:0]   link_o,
  output logic [XW-1:0]   pcrel_o,
  output logic            misalign_o
);
  localparam logic [XW-1:0] STEP_HALF = XW'(2);
  localparam logic [XW-1:0] STEP_FULL = XW'(4);

  logic [XW-1:0] step, seq_pc, rel_pc, reg_pc;
  logic          is_branch, br_hit;
  cmp_kind_e     kind;

  assign step = (len_i == LENW'(2)) ? STEP_HALF : STEP_FULL;
  assign kind = cmp_kind_e'(op_i[2:1]);
  assign is_branch = op_i[3] && (kind != CMP_NONE);

  npc_target #(.W(XW)) u_target (
    .pc_i   (pc_i),
    .base_i (opa_i),
    .off_i  (off_i),
    .step_i (step),
    .seq_o  (seq_pc),
    .rel_o  (rel_pc),
    .reg_o  (reg_pc)
  );

  npc_branch_cmp #(.W(XW)) u_cmp (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .kind_i   (kind),
    .invert_i (op_i[0]),
    .hit_o    (br_hit)
  );

  always_comb begin
    next_pc_o = seq_pc;
    taken_o   = 1'b0;
    if (op_i == NPC_JMP) begin
      next_pc_o = rel_pc;
      taken_o   = 1'b1;
    end else if (op_i == NPC_JREG) begin
      next_pc_o = reg_pc;
      taken_o   = 1'b1;
    end else if (is_branch && br_hit) begin
      next_pc_o = rel_pc;
      taken_o   = 1'b1;
    end
  end

  assign link_o  = seq_pc;
  assign pcrel_o = rel_pc;

  generate
    if (HALF_OK) begin : g_half
      assign misalign_o = 1'b0;
    end else begin : g_full
      assign misalign_o = taken_o & next_pc_o[1];
    end
  endgenerate

  always_comb begin
    if (!$isunknown({pc_i, opa_i, opb_i, off_i, op_i, len_i})) begin
      // R12: redirects come only from jump and branch codes
      a_r12_taken_kinds: assert (!taken_o || op_i == NPC_JMP || op_i == NPC_JREG
                                 || (op_i >= NPC_BEQ && op_i <= NPC_BGEU));
      // R10: a flow that is not redirected lands on the return address
      a_r10_fallthru: assert (taken_o || next_pc_o == link_o);
      // R6: the PC-relative add never redirects
      a_r6_pcrel_seq: assert (op_i != NPC_PCREL || !taken_o);
      // R11: misalignment is reported only on a redirect
      a_r11_misalign_taken: assert (!misalign_o || taken_o);
      // R4: register jump targets are even
      a_r4_jreg_even: assert (op_i != NPC_JREG || !next_pc_o[0]);
    end
  end
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic [63:0] pc, opa, opb, off;
  logic [3:0]  op;
  logic [2:0]  len;
  logic [63:0] next_pc, link, pcrel;
  logic        taken, misalign;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  npc_unit u_dut (
    .pc_i(pc), .opa_i(opa), .opb_i(opb), .off_i(off), .op_i(op), .len_i(len),
    .next_pc_o(next_pc), .taken_o(taken), .link_o(link), .pcrel_o(pcrel),
    .misalign_o(misalign)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [63:0] p, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] f, input logic [2:0] l);
    @(negedge clk);
    op = o; pc = p; opa = a; opb = b; off = f; len = l;
    #1;
  endtask

  task automatic t_idle();
    @(negedge clk); #1;
    chk("R1 idle next", next_pc, 64'd4);
    chk("R1 idle taken", {63'd0, taken}, 64'd0);
  endtask

  task automatic t_seq();
    apply(4'd0, 64'h1000, 0, 0, 64'h40, 3'd4);
    chk("R1 seq", next_pc, 64'h1004);
    chk("R1 seq taken", {63'd0, taken}, 64'd0);
    apply(4'd0, 64'h1000, 0, 0, 64'h40, 3'd2);
    chk("R2 half step", next_pc, 64'h1002);
    apply(4'd0, 64'h1000, 0, 0, 64'h40, 3'd7);
    chk("R2 odd len", next_pc, 64'h1004);
    apply(4'd5, 64'h1000, 5, 5, 64'h40, 3'd4);
    chk("R1 code5", next_pc, 64'h1004);
    chk("R1 code5 taken", {63'd0, taken}, 64'd0);
    apply(4'd14, 64'h1000, 5, 5, 64'h40, 3'd4);
    chk("R1 code14", next_pc, 64'h1004);
    apply(4'd15, 64'h1000, 5, 6, 64'h40, 3'd4);
    chk("R12 code15 taken", {63'd0, taken}, 64'd0);
  endtask

  task automatic t_jump();
    apply(4'd1, 64'h2000, 0, 0, -64'sd16, 3'd4);
    chk("R3 jmp target", next_pc, 64'h1FF0);
    chk("R3 jmp taken", {63'd0, taken}, 64'd1);
    chk("R5 jmp link", link, 64'h2004);
    apply(4'd1, 64'h2000, 0, 0, 64'h20, 3'd2);
    chk("R5 jmp link half", link, 64'h2002);
    apply(4'd2, 64'h2000, 64'h3001, 0, 64'h10, 3'd4);
    chk("R4 jreg target", next_pc, 64'h3010);
    chk("R4 jreg taken", {63'd0, taken}, 64'd1);
    chk("R5 jreg link", link, 64'h2004);
  endtask

  task automatic t_pcrel();
    apply(4'd3, 64'h4000, 0, 0, 64'h12345000, 3'd4);
    chk("R6 pcrel sum", pcrel, 64'h12349000);
    chk("R6 pcrel next", next_pc, 64'h4004);
    chk("R6 pcrel taken", {63'd0, taken}, 64'd0);
  endtask

  task automatic t_branch();
    apply(4'd8, 64'h5000, 5, 5, 64'h80, 3'd4);
    chk("R7 beq hit", next_pc, 64'h5080);
    chk("R12 beq taken", {63'd0, taken}, 64'd1);
    apply(4'd9, 64'h5000, 5, 5, 64'h80, 3'd4);
    chk("R10 bne fall", next_pc, 64'h5004);
    chk("R7 bne taken", {63'd0, taken}, 64'd0);
    apply(4'd10, 64'h5000, '1, 64'd1, 64'h80, 3'd4);
    chk("R8 blt -1<1", next_pc, 64'h5080);
    apply(4'd12, 64'h5000, '1, 64'd1, 64'h80, 3'd4);
    chk("R9 bltu max<1", next_pc, 64'h5004);
    apply(4'd11, 64'h5000, 64'd7, 64'd7, 64'h80, 3'd2);
    chk("R8 bge equal", next_pc, 64'h5080);
    apply(4'd11, 64'h5000, '1, 64'd1, 64'h80, 3'd2);
    chk("R8 bge -1", next_pc, 64'h5002);
    apply(4'd13, 64'h5000, 64'd1, '1, 64'h80, 3'd4);
    chk("R9 bgeu 1", next_pc, 64'h5004);
    apply(4'd13, 64'h5000, 64'd9, 64'd9, 64'h80, 3'd4);
    chk("R9 bgeu equal", next_pc, 64'h5080);
  endtask

  task automatic t_misalign();
    apply(4'd1, 64'h1000, 0, 0, 64'd6, 3'd4);
    chk("R11 jmp misalign", {63'd0, misalign}, 64'd1);
    apply(4'd8, 64'h1000, 1, 2, 64'd6, 3'd4);
    chk("R11 fall no flag", {63'd0, misalign}, 64'd0);
    apply(4'd8, 64'h1000, 2, 2, 64'd6, 3'd4);
    chk("R11 branch misalign", {63'd0, misalign}, 64'd1);
    apply(4'd2, 64'h1000, 64'h2003, 0, 64'd0, 3'd4);
    chk("R11 jreg misalign", {63'd0, misalign}, 64'd1);
    apply(4'd0, 64'h1002, 0, 0, 0, 3'd4);
    chk("R11 seq no flag", {63'd0, misalign}, 64'd0);
  endtask

  initial begin
    pc = '0; opa = '0; opb = '0; off = '0; op = '0; len = 3'd4;
    t_idle();
    t_seq();
    t_jump();
    t_pcrel();
    t_branch();
    t_misalign();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule